// File: doc/BRIEF.md
# Offset Calibration Sequencer

This block runs one output-offset nulling pass each time it is triggered. On a trigger it first waits a fixed settling interval so that a freshly applied delay setting can settle. It then drives a control that ties the signal inputs together and performs a successive-approximation search on the code of an offset-correction DAC. During the search it reads a comparator that reports whether the residual offset is still negative. When the last bit is decided it releases the input short, holds the final code and flags completion.

All timing is counted in clock cycles. At the 250 MHz default the settle time is 500 ns and the nulling phase is 2.5 µs, so a full pass takes about 3 µs. Triggers that arrive while a pass is running are dropped. Pulling the chip-enable input low puts the block in standby. Standby aborts any pass, returns the code to mid-scale and marks the code invalid until the next completed calibration.

The controller has four states: `ST_IDLE`, `ST_SETTLE`, `ST_NULL` and `ST_DONE`. Its transitions are:
- **start**: `ST_IDLE` to `ST_SETTLE`, on a trigger with chip enable high.
- **settled**: `ST_SETTLE` to `ST_NULL`, when the settle count expires.
- **next bit**: `ST_NULL` to `ST_NULL`, at the end of every step except the last.
- **resolved**: `ST_NULL` to `ST_DONE`, at the end of the last step.
- **retire**: `ST_DONE` to `ST_IDLE`, always after one cycle.
- **standby**: any state to `ST_IDLE`, whenever chip enable is low.

Top module: `offset_cal_seq`

## Requirements
- R1: After reset the block is idle and drives `busy`, `done`, `short_en` and `code_valid` low. `dac_code` reads mid-scale, which is 2^(CODE_W-1) (0x80 for 8 bits).
- R2: The block samples `trig` on the rising clock edge. If `trig` is high while the block is idle and `chip_en` is high, a pass starts. `busy` goes high on the next cycle and stays high up to and including the `done` cycle, then drops on the following cycle.
- R3: For the first SETTLE_CYC cycles after the trigger edge, `short_en` stays low.
- R4: `short_en` is high for exactly CODE_W*STEP_CYC consecutive cycles per pass, and only while `busy` is high.
- R5: Bits are decided MSB first, and each bit is given STEP_CYC cycles. Each trial sets the bit under test on top of the bits already kept. The comparator input `cmp_low` is sampled in the last cycle of the step. If `cmp_low` is 1 the bit is kept; if it is 0 the bit is cleared. When `cmp_low` is 1 exactly while `dac_code` is at or below a target T, the final code equals T.
- R6: `done` is a single-cycle pulse. It appears SETTLE_CYC + CODE_W*STEP_CYC cycles after the trigger edge. In that cycle `short_en` is low and `dac_code` carries the final code. From the next cycle on, `code_valid` is high.
- R7: A `trig` pulse while `busy` is high is ignored: it does not change the length or the result of the running pass.
- R8: When `chip_en` is low at a clock edge, on the next cycle `busy` and `short_en` are low, `code_valid` is low and `dac_code` is mid-scale. A `trig` while `chip_en` is low starts nothing.
- R9: While the block is idle and enabled, `dac_code` holds its value whatever `cmp_low` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chip_en | input | 1 | Chip enable; low means standby |
| trig | input | 1 | Calibration request, sampled on the clock edge |
| cmp_low | input | 1 | Comparator result: 1 when the residual offset is still below zero |
| short_en | output | 1 | Ties the signal inputs together during nulling |
| dac_code | output | CODE_W | Offset-correction DAC code |
| code_valid | output | 1 | Code comes from a completed calibration |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle pulse when a pass completes |

## Verification
A wrong state or a miscounting timer shows up first as a wrong count of `short_en` cycles or as `done` arriving at a different cycle. Both are visible within a single pass of about 750 cycles. A fault in the approximation register, such as a wrong bit order, a comparator sampled in the wrong cycle or an inverted keep rule, leaves the final code different from the comparator's threshold. Such a fault is seen at the `done` cycle for targets that exercise the extreme bits and alternating bit patterns. Faults in standby handling appear one cycle after `chip_en` falls, as a code other than mid-scale or a `code_valid` that is still set.

// File: rtl/offcal_pkg.sv
package offcal_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_NULL,
        ST_DONE
    } cal_state_t;
endpackage

// File: rtl/cal_step_timer.sv
module cal_step_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sar_register.sv
module sar_register #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              start,
    input  logic              step,
    input  logic              keep,
    output logic [CODE_W-1:0] code,
    output logic              last_bit
);
    localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= MID;
            mask_q <= '0;
        end else if (clear) begin
            code_q <= MID;
            mask_q <= '0;
        end else if (start) begin
            code_q <= MID;
            mask_q <= MID;
        end else if (step) begin
            code_q <= (keep ? code_q : (code_q & ~mask_q)) | (mask_q >> 1);
            mask_q <= mask_q >> 1;
        end
    end

    assign code     = code_q;
    assign last_bit = mask_q[0];

    AST_STEP_ONE_TRIAL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && !start) |=> $countones(mask_q) <= 1); // R5
endmodule

// File: rtl/offset_cal_seq.sv
module offset_cal_seq
    import offcal_pkg::*;
#(
    parameter int CODE_W     = 8,
    parameter int SETTLE_CYC = 125,
    parameter int STEP_CYC   = 78
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en,
    input  logic              trig,
    input  logic              cmp_low,
    output logic              short_en,
    output logic [CODE_W-1:0] dac_code,
    output logic              code_valid,
    output logic              busy,
    output logic              done
);
    localparam int MAXV  = (SETTLE_CYC > STEP_CYC) ? SETTLE_CYC : STEP_CYC;
    localparam int CNT_W = $clog2(MAXV + 1);
    localparam logic [CNT_W-1:0]  SETTLE_LD = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0]  STEP_LD   = CNT_W'(STEP_CYC - 1);
    localparam logic [CODE_W-1:0] MID       = {1'b1, {(CODE_W-1){1'b0}}};

    cal_state_t state_q, state_d;
    logic             t_load, t_expired;
    logic [CNT_W-1:0] t_val;
    logic             s_clear, s_start, s_step, s_last;
    logic             valid_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions and control strobes
    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = STEP_LD;
        s_start = 1'b0;
        s_step  = 1'b0;
        s_clear = !chip_en;
        if (!chip_en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (trig) begin
                    state_d = ST_SETTLE;
                    t_load  = 1'b1;
                    t_val   = SETTLE_LD;
                end
                ST_SETTLE: if (t_expired) begin
                    state_d = ST_NULL;
                    t_load  = 1'b1;
                    s_start = 1'b1;
                end
                ST_NULL: if (t_expired) begin
                    s_step = 1'b1;
                    if (s_last) state_d = ST_DONE;
                    else        t_load  = 1'b1;
                end
                ST_DONE: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs from state
    always_comb begin
        short_en = 1'b0;
        busy     = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_SETTLE: busy = 1'b1;
            ST_NULL: begin
                busy     = 1'b1;
                short_en = 1'b1;
            end
            ST_DONE: begin
                busy = 1'b1;
                done = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  valid_q <= 1'b0;
        else if (!chip_en)           valid_q <= 1'b0;
        else if (s_start)            valid_q <= 1'b0;
        else if (state_q == ST_DONE) valid_q <= 1'b1;
    end
    assign code_valid = valid_q;

    cal_step_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_expired)
    );

    sar_register #(.CODE_W(CODE_W)) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (s_clear),
        .start    (s_start),
        .step     (s_step),
        .keep     (cmp_low),
        .code     (dac_code),
        .last_bit (s_last)
    );

    AST_SHORT_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        short_en |-> busy); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R2
    AST_DONE_NO_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !short_en); // R6
    AST_DONE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (done && chip_en) |=> code_valid); // R6
    AST_STANDBY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |=> (!busy && !code_valid && dac_code == MID)); // R8
    AST_IDLE_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy) && chip_en && $past(chip_en)) |-> $stable(dac_code)); // R9
    AST_SETTLE_NO_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && chip_en && trig) |=> !short_en); // R3
endmodule

// File: tb/offset_cal_seq_tb.sv
`timescale 1ns/1ps
module offset_cal_seq_tb;
    localparam int CODE_W = 8;
    localparam int SETTLE = 125;
    localparam int STEP   = 78;
    localparam int PASS_K = SETTLE + CODE_W*STEP;
    localparam int NVEC   = 8;
    // {target threshold, expected final code}
    localparam logic [15:0] VEC [NVEC] = '{
        16'h0000, 16'hFFFF, 16'h8080, 16'h7F7F,
        16'h0101, 16'hA5A5, 16'h5A5A, 16'hFEFE
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chip_en = 1'b0;
    logic trig = 1'b0;
    logic cmp_low;
    logic short_en, code_valid, busy, done;
    logic [CODE_W-1:0] dac_code;
    logic [CODE_W-1:0] target = '0;
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;
    assign cmp_low = (dac_code <= target);

    offset_cal_seq #(.CODE_W(CODE_W), .SETTLE_CYC(SETTLE), .STEP_CYC(STEP)) u_dut (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .trig(trig), .cmp_low(cmp_low),
        .short_en(short_en), .dac_code(dac_code), .code_valid(code_valid),
        .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // one pass; optional second trigger at cycle 10 (R7)
    task automatic run_cal(input logic [7:0] tgt, input logic [7:0] exp, input bit extra);
        int cyc = 0;
        int shorts = 0;
        int nobusy = 0;
        int early_short = 0;
        target = tgt;
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
        while (!done && cyc < PASS_K + 50) begin
            if (short_en) shorts++;
            if (short_en && cyc < SETTLE) early_short++;
            if (!busy) nobusy++;
            @(negedge clk);
            cyc++;
            if (extra && cyc == 10) trig = 1'b1;
            if (extra && cyc == 11) trig = 1'b0;
        end
        chk(cyc == PASS_K, extra ? "R7 done timing with extra trig" : "R6 done timing", cyc, PASS_K);
        chk(shorts == CODE_W*STEP, "R4 short cycles", shorts, CODE_W*STEP);
        chk(early_short == 0, "R3 short during settle", early_short, 0);
        chk(nobusy == 0, "R2 busy through pass", nobusy, 0);
        chk(dac_code == exp, extra ? "R7 code with extra trig" : "R5 final code", dac_code, exp);
        chk(!short_en, "R6 short released at done", short_en, 0);
        @(negedge clk);
        chk(!done && !busy, "R2 done single, busy drops", {done, busy}, 0);
        chk(code_valid, "R6 valid after done", code_valid, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !short_en && !code_valid, "R1 reset outputs",
            {busy, done, short_en, code_valid}, 0);
        chk(dac_code == 8'h80, "R1 reset code", dac_code, 8'h80);
        rst_n = 1'b1;
        @(negedge clk);
        chip_en = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            run_cal(VEC[i][15:8], VEC[i][7:0], 1'b0);
        end

        run_cal(8'h3C, 8'h3C, 1'b1);

        // R9: idle code holds while comparator moves
        target = 8'h00;
        repeat (20) @(negedge clk);
        chk(dac_code == 8'h3C, "R9 idle code hold", dac_code, 8'h3C);
        target = 8'hFF;
        repeat (20) @(negedge clk);
        chk(dac_code == 8'h3C && !busy, "R9 idle code hold", dac_code, 8'h3C);

        // R8: standby clears
        chip_en = 1'b0;
        @(negedge clk);
        chk(!code_valid && dac_code == 8'h80, "R8 standby clears code", dac_code, 8'h80);
        trig = 1'b1;
        @(negedge clk); trig = 1'b0;
        @(negedge clk);
        chk(!busy && !short_en, "R8 trig in standby ignored", busy, 0);

        // R8: abort mid search
        chip_en = 1'b1;
        target = 8'h11;
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
        repeat (SETTLE + 3*STEP) @(negedge clk);
        chk(short_en && busy, "R4 short high mid search", short_en, 1);
        chip_en = 1'b0;
        @(negedge clk);
        chk(!busy && !short_en && !code_valid, "R8 abort outputs",
            {busy, short_en, code_valid}, 0);
        chk(dac_code == 8'h80, "R8 abort code mid", dac_code, 8'h80);
        chip_en = 1'b1;
        repeat (5) @(negedge clk);
        chk(!busy && dac_code == 8'h80, "R9 stays idle after standby", dac_code, 8'h80);

        run_cal(8'h11, 8'h11, 1'b0);
        summary();
    end
endmodule